// File: doc/BRIEF.md
# Mode-Banked Shadow Register File

This block is a 32-entry integer register file with 64-bit entries, two independent read ports and one write port. A privileged-mode input selects between two views of the same register numbers. In the privileged view, a fixed group of eight register numbers is steered to a separate bank of eight shadow entries. Privileged code can then use those registers as scratch space without saving and restoring the values that normal code holds in them.

The steered group is register numbers 8 through 14 plus register number 25. Every other register number reaches the same storage in both modes. With the mode input low, every number reaches the normal bank and the shadow bank is left untouched. Reads are combinational. Writes commit on the rising clock edge, using the mode value present in that same cycle. Register 31 is a constant zero.

Top module: `shadow_regfile`

## Requirements
- R1: With `priv_mode` high, register numbers 8 to 14 read and write shadow entries 0 to 6, in that order.
- R2: With `priv_mode` high, register number 25 reads and writes shadow entry 7.
- R3: With `priv_mode` low, every register number reaches the normal bank. The shadow bank is not read, and writes leave it unchanged.
- R4: Entries are 64 bits wide and register numbers are 5 bits wide. The two read ports return their own addressed entries independently in the same cycle.
- R5: A value written through a register number is returned by a later read of that number in the same mode.
- R6: Register number 31 reads as zero on both ports in both modes, and writes to it change nothing.
- R7: A write takes effect at the rising clock edge. A read of the entry being written in that same cycle returns the previous value, and the new value appears after the edge.
- R8: A synchronous active-high `rst` clears every entry of both banks to zero.
- R9: A write is steered by the value of `priv_mode` in the cycle in which `we` is high. Changing the mode in that cycle moves the write to the bank of the new mode.
- R10: Register numbers outside the steered group share one entry across both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears both banks |
| priv_mode | input | 1 | High selects the privileged view with the shadow bank |
| we | input | 1 | Write enable |
| waddr | input | 5 | Register number written |
| wdata | input | 64 | Data written |
| raddr_a | input | 5 | Register number for read port A |
| rdata_a | output | 64 | Read port A data |
| raddr_b | input | 5 | Register number for read port B |
| rdata_b | output | 64 | Read port B data |

## Verification
Two things can happen in one cycle: a write commits to an entry while a read port addresses that same entry. The mode can also change in the cycle that carries the write. The bench provokes the first case by driving `we`, `waddr` and `raddr_a` to the same register number in one cycle, in both modes. Before the edge, the read must show the old model value; after the edge, it must show the new one. For the second case, the bench raises or lowers `priv_mode` together with `we` on a steered number. It then reads that number in both modes and judges which bank received the data against a model of the two banks that the bench keeps itself.

// File: rtl/srf_pkg.sv
package srf_pkg;

    localparam int DATA_W     = 64;
    localparam int IDX_W      = 5;
    localparam int NUM_ARCH   = 1 << IDX_W;
    localparam int NUM_SHADOW = 8;
    localparam int SLOT_W     = $clog2(NUM_SHADOW);
    localparam int RUN_BASE   = 8;
    localparam int RUN_LEN    = 7;
    localparam int LONE_IDX   = 25;
    localparam int ZERO_IDX   = NUM_ARCH - 1;
    localparam int NUM_RD     = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  shadow;
        slot_t slot;
        idx_t  idx;
    } map_t;

    // True for register numbers that the privileged view steers to shadow storage
    function automatic logic is_banked(idx_t idx);
        return ((int'(idx) >= RUN_BASE) && (int'(idx) < RUN_BASE + RUN_LEN))
               || (int'(idx) == LONE_IDX);
    endfunction

    // Shadow entry for a steered register number
    function automatic slot_t slot_of(idx_t idx);
        if (int'(idx) == LONE_IDX)
            return slot_t'(RUN_LEN);
        return slot_t'(int'(idx) - RUN_BASE);
    endfunction

endpackage

// File: rtl/srf_remap.sv
module srf_remap
    import srf_pkg::*;
(
    input  logic priv,
    input  idx_t idx,
    output map_t map
);
    always_comb begin
        map.idx    = idx;
        map.shadow = priv && is_banked(idx);
        map.slot   = slot_of(idx);
    end
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int DEPTH     = 32,
    parameter int W         = 64,
    parameter bit ZERO_LAST = 1'b0,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata0,
    output logic [W-1:0]  rdata1
);
    logic [W-1:0] cells [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        if (ZERO_LAST && (e == DEPTH - 1)) begin : g_const
            assign cells[e] = '0;
        end else begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && (int'(waddr) == e))
                    q <= wdata;
            end
            assign cells[e] = q;
        end
    end

    assign rdata0 = cells[raddr0];
    assign rdata1 = cells[raddr1];
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_mode,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    idx_t  rd_idx [NUM_RD];
    map_t  rd_map [NUM_RD];
    word_t nm_rd  [NUM_RD];
    word_t sh_rd  [NUM_RD];
    word_t rd_out [NUM_RD];
    map_t  wr_map;

    assign rd_idx[0] = raddr_a;
    assign rd_idx[1] = raddr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
        srf_remap u_rmap (
            .priv (priv_mode),
            .idx  (rd_idx[p]),
            .map  (rd_map[p])
        );
        assign rd_out[p] = rd_map[p].shadow ? sh_rd[p] : nm_rd[p];
    end

    srf_remap u_wmap (
        .priv (priv_mode),
        .idx  (waddr),
        .map  (wr_map)
    );

    srf_bank #(
        .DEPTH     (NUM_ARCH),
        .W         (DATA_W),
        .ZERO_LAST (1'b1)
    ) u_normal (
        .clk    (clk),
        .rst    (rst),
        .we     (we && !wr_map.shadow),
        .waddr  (wr_map.idx),
        .wdata  (wdata),
        .raddr0 (rd_map[0].idx),
        .raddr1 (rd_map[1].idx),
        .rdata0 (nm_rd[0]),
        .rdata1 (nm_rd[1])
    );

    srf_bank #(
        .DEPTH     (NUM_SHADOW),
        .W         (DATA_W),
        .ZERO_LAST (1'b0)
    ) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .we     (we && wr_map.shadow),
        .waddr  (wr_map.slot),
        .wdata  (wdata),
        .raddr0 (rd_map[0].slot),
        .raddr1 (rd_map[1].slot),
        .rdata0 (sh_rd[0]),
        .rdata1 (sh_rd[1])
    );

    assign rdata_a = rd_out[0];
    assign rdata_b = rd_out[1];
endmodule

// File: rtl/shadow_regfile_chk.sv
module shadow_regfile_chk
    import srf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              priv_mode,
    input logic              we,
    input logic [IDX_W-1:0]  waddr,
    input logic [DATA_W-1:0] wdata,
    input logic [IDX_W-1:0]  raddr_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic [IDX_W-1:0]  raddr_b,
    input logic [DATA_W-1:0] rdata_b
);
    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
        (int'(raddr_b) == ZERO_IDX) |-> (rdata_b == '0)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((rdata_a == '0) && (rdata_b == '0))); // R8

    AST_HOLD_OLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we) && $stable(raddr_a) && $stable(priv_mode))
        |-> $stable(rdata_a)); // R7

    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we) && ($past(waddr) == raddr_a)
         && ($past(priv_mode) == priv_mode) && (int'(raddr_a) != ZERO_IDX))
        |-> (rdata_a == $past(wdata))); // R5

    AST_SHARED_INDEX: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we) && ($past(waddr) == raddr_a)
         && !is_banked(raddr_a) && (int'(raddr_a) != ZERO_IDX))
        |-> (rdata_a == $past(wdata))); // R10
endmodule

bind shadow_regfile shadow_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .priv_mode (priv_mode),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .raddr_a   (raddr_a),
    .rdata_a   (rdata_a),
    .raddr_b   (raddr_b),
    .rdata_b   (rdata_b)
);

// File: tb/shadow_regfile_bench.sv
`timescale 1ns/1ps
module shadow_regfile_bench;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv_mode = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  waddr = '0;
    logic [63:0] wdata = '0;
    logic [4:0]  raddr_a = '0;
    logic [63:0] rdata_a;
    logic [4:0]  raddr_b = '0;
    logic [63:0] rdata_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    logic [63:0] m_norm [32];
    logic [63:0] m_sh   [8];

    always #(HALF) clk = ~clk;

    shadow_regfile u_shadow_regfile (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .we(we),
        .waddr(waddr), .wdata(wdata),
        .raddr_a(raddr_a), .rdata_a(rdata_a),
        .raddr_b(raddr_b), .rdata_b(rdata_b)
    );

    function automatic bit steered(bit p, int idx);
        return p && (((idx >= 8) && (idx <= 14)) || (idx == 25));
    endfunction

    function automatic int shadow_slot(int idx);
        return (idx == 25) ? 7 : idx - 8;
    endfunction

    function automatic logic [63:0] expect_val(bit p, int idx);
        if (idx == 31) return 64'd0;
        if (steered(p, idx)) return m_sh[shadow_slot(idx)];
        return m_norm[idx];
    endfunction

    function automatic logic [63:0] pattern(int idx, int seed);
        return 64'h8123_4567_89AB_CDEF ^ (64'(idx) * 64'h0101_0101_0101_0101)
               ^ (64'(seed) << 40);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 32; i++) m_norm[i] = '0;
        for (int i = 0; i < 8; i++) m_sh[i] = '0;
    endtask

    task automatic model_write(bit p, int idx, logic [63:0] d);
        if (idx == 31) return;
        if (steered(p, idx)) m_sh[shadow_slot(idx)] = d;
        else m_norm[idx] = d;
    endtask

    task automatic compare(string tag, logic [63:0] act, logic [63:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic wr(bit p, int idx, logic [63:0] d);
        @(negedge clk);
        priv_mode = p; we = 1'b1; waddr = 5'(idx); wdata = d;
        @(posedge clk);
        #1;
        we = 1'b0;
        model_write(p, idx, d);
    endtask

    task automatic rd(bit p, int idx, string tag);
        @(negedge clk);
        priv_mode = p; raddr_a = 5'(idx); raddr_b = 5'(31 - idx);
        #1;
        compare($sformatf("%s port A mode %0d idx %0d", tag, p, idx), rdata_a, expect_val(p, idx));
        compare($sformatf("%s port B mode %0d idx %0d", tag, p, 31 - idx), rdata_b, expect_val(p, 31 - idx));
    endtask

    task automatic sweep(string tag);
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 32; i++)
                rd(bit'(p), i, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Same-cycle write and read of one entry: old value before the edge, new after
    task automatic rdw(bit p, int idx, logic [63:0] d);
        logic [63:0] old_v;
        old_v = expect_val(p, idx);
        @(negedge clk);
        priv_mode = p; we = 1'b1; waddr = 5'(idx); wdata = d; raddr_a = 5'(idx);
        #1;
        compare($sformatf("R7 old value idx %0d mode %0d", idx, p), rdata_a, old_v);
        @(posedge clk);
        #1;
        we = 1'b0;
        model_write(p, idx, d);
        compare($sformatf("R7 new value idx %0d mode %0d", idx, p), rdata_a, expect_val(p, idx));
    endtask

    initial begin
        #(HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: both banks read zero after reset
        sweep("R8 reset state");

        // R3, R4, R6: normal-mode fill of every index, shadow stays zero
        for (int i = 0; i < 32; i++) wr(1'b0, i, pattern(i, 1));
        sweep("R3 R4 R6 normal fill");

        // R1, R2, R5: privileged fill; steered numbers land in shadow entries
        for (int i = 0; i < 32; i++) wr(1'b1, i, pattern(i, 2));
        sweep("R1 R2 R5 R10 privileged fill");

        // R1 R2: each shadow entry distinct, normal copies kept
        for (int s = 0; s < 8; s++) wr(1'b1, (s == 7) ? 25 : 8 + s, 64'(s) * 64'h1111_0000_0000_0001);
        for (int i = 8; i <= 14; i++) rd(1'b1, i, "R1 shadow entry");
        rd(1'b1, 25, "R2 shadow entry");
        rd(1'b0, 25, "R3 normal copy of 25");
        rd(1'b0, 8, "R3 normal copy of 8");

        // R6: writes to register 31 ignored
        wr(1'b0, 31, '1);
        wr(1'b1, 31, '1);
        rd(1'b0, 31, "R6 zero register");
        rd(1'b1, 31, "R6 zero register");

        // R7: read during write, both modes
        rdw(1'b0, 3, 64'hDEAD_BEEF_0000_0003);
        rdw(1'b1, 9, 64'hFEED_0000_0000_0009);
        rdw(1'b1, 25, 64'hC0DE_0000_0000_0019);
        rdw(1'b0, 12, 64'h1234_0000_0000_000C);
        rdw(1'b1, 31, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9: mode changes together with the write
        @(negedge clk);
        priv_mode = 1'b0; raddr_a = 5'd9;
        wr(1'b1, 9, 64'hAAAA_0000_0000_0009);
        wr(1'b0, 9, 64'h5555_0000_0000_0009);
        wr(1'b1, 25, 64'hAAAA_0000_0000_0019);
        rd(1'b1, 9, "R9 privileged write steered");
        rd(1'b0, 9, "R9 normal write steered");
        rd(1'b1, 25, "R9 privileged write steered");
        rd(1'b0, 25, "R9 normal copy untouched");

        // R10: non-steered index written in one mode, read in the other
        wr(1'b1, 20, 64'h2020_2020_2020_2020);
        rd(1'b0, 20, "R10 shared index");
        wr(1'b0, 7, 64'h0707_0707_0707_0707);
        rd(1'b1, 7, "R10 shared index");
        wr(1'b0, 15, 64'h0F0F_0F0F_0F0F_0F0F);
        rd(1'b1, 15, "R10 shared index");

        // R8: reset mid-run clears both banks
        do_reset();
        sweep("R8 reset after use");

        report();
    end
endmodule